// File: doc/BRIEF.md
# Compressed Instruction Expander

This purely combinational unit converts one 16-bit compressed RISC-V instruction into the 32-bit base instruction it stands for. It covers these forms:

- the stack-pointer-relative word and doubleword loads;
- the register jump, jump-and-link, move and add forms;
- the load-immediate and load-upper-immediate forms;
- the add-immediate family: add-immediate, 32-bit add-immediate, stack-pointer adjust by 16 and stack-pointer address generation.

A front end places it between the fetch buffer and the 32-bit decoder. The decoder then sees only base instructions, together with two classification bits.

A select input chooses 32-bit or 64-bit integer width. The unit sorts every corner code point into one of three classes:

- **Reserved:** raises `illegal_o`.
- **HINT:** raises `hint_o` and still produces the architectural expansion, which has no architectural effect.
- **Alias:** decodes to another instruction, such as the no-op, the breakpoint, the register jumps or the stack-pointer adjust.

Encodings outside the covered set also raise `illegal_o`. Whenever `illegal_o` is high the expansion word is forced to zero.

Top module: `cx_expander`

## Requirements
Field notation: `c[m:n]` is the input instruction, `rd` is `c[11:7]`, `rs2` is `c[6:2]` and `f3` is `c[15:13]`. A 6-bit signed immediate `k6` is `{c[12], c[6:2]}`.

- R1: An input whose low two bits are 2'b11, or the all-zero input, gives `illegal_o`=1 and `hint_o`=0. Any illegal result drives `insn_o`=32'h0.
- R2: With `c[1:0]`=00 and `f3`=000, the expansion is `addi x(8+c[4:2]), x2, u`. Here `u` is zero-extended, and `u[5:4]`=`c[12:11]`, `u[9:6]`=`c[10:7]`, `u[2]`=`c[6]`, `u[3]`=`c[5]`. A value of `u`=0 is illegal.
- R3: With `c[1:0]`=10 and `f3`=010, the expansion is `lw rd, u(x2)`. Here `u[5]`=`c[12]`, `u[4:2]`=`c[6:4]`, `u[7:6]`=`c[3:2]`, zero-extended. `rd`=0 is illegal.
- R4: With `c[1:0]`=10 and `f3`=011 and `xlen64_i`=1, the expansion is `ld rd, u(x2)`. Here `u[5]`=`c[12]`, `u[4:3]`=`c[6:5]`, `u[8:6]`=`c[4:2]`. `rd`=0 is illegal. With `xlen64_i`=0 this encoding is illegal.
- R5: With `c[1:0]`=10, `f3`=100 and `rs2`=0:
  - `c[12]`=0 gives `jalr x0, 0(rd)`, and `rd`=0 is illegal.
  - `c[12]`=1 gives `jalr x1, 0(rd)`.
  - `c[12]`=1 with `rd`=0 gives the breakpoint word 32'h00100073.
- R6: With `c[1:0]`=10, `f3`=100 and `rs2`≠0, `c[12]`=0 gives `add rd, x0, rs2` and `c[12]`=1 gives `add rd, rd, rs2`. `rd`=0 sets `hint_o`.
- R7: With `c[1:0]`=01 and `f3`=010, the expansion is `addi rd, x0, sext(k6)`. `rd`=0 sets `hint_o`.
- R8: With `c[1:0]`=01, `f3`=011 and `rd`≠2, the expansion is `lui rd, sext(k6)`, so `k6` lands in result bits 17:12. `k6`=0 is illegal. Otherwise `rd`=0 sets `hint_o`.
- R9: With `c[1:0]`=01, `f3`=011 and `rd`=2, the expansion is `addi x2, x2, n`. Here `n[9]`=`c[12]`, `n[4]`=`c[6]`, `n[6]`=`c[5]`, `n[8:7]`=`c[4:3]`, `n[5]`=`c[2]`, and `n[3:0]`=0, giving the range -512..496. `n`=0 is illegal.
- R10: With `c[1:0]`=01 and `f3`=000, the expansion is `addi rd, rd, sext(k6)`. `hint_o` is set when exactly one of `rd` and `k6` is zero. `rd`=0 with `k6`=0 is the no-op 32'h00000013 with no hint.
- R11: With `c[1:0]`=01, `f3`=001 and `xlen64_i`=1, the expansion is `addiw rd, rd, sext(k6)`. `k6`=0 is a legal non-HINT, and `rd`=0 is illegal. With `xlen64_i`=0 this encoding is illegal.
- R12: Every other compressed encoding (the remaining `f3` values of each quadrant) is illegal.
- R13: `illegal_o` and `hint_o` are never both 1. Every legal expansion has bits 1:0 equal to 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cinsn_i | input | 16 | Compressed instruction to expand |
| xlen64_i | input | 1 | 1 selects 64-bit integer width, 0 selects 32-bit |
| insn_o | output | 32 | Equivalent 32-bit instruction, zero when illegal |
| illegal_o | output | 1 | Reserved or unsupported encoding |
| hint_o | output | 1 | Legal encoding that is a HINT |

## Verification
The assertions run on every evaluation and cover the cross-output invariants:

- the illegal flag forces a zero word;
- the two flags never overlap;
- legal words carry the 32-bit length marker;
- non-compressed inputs and 64-bit-only forms under 32-bit width are refused;
- register jumps keep their source register.

Only the bench's scenarios show that each immediate is scrambled into the right bit positions and sign- or zero-extended correctly. The bench's scenarios also show that each x0 or zero-immediate code point lands in its intended class (reserved, HINT or alias). Both of these need expected words computed from the field layouts.

// File: rtl/cx_pkg.sv
// Package cx_pkg
// Shared widths, 32-bit opcodes and encoders for the compressed expander.
// Assumes the 32-bit formats of the base integer ISA.
package cx_pkg;
    localparam int CW = 16;   // compressed instruction width
    localparam int XW = 32;   // expanded instruction width
    localparam int RW = 5;    // register index width
    localparam int IW = 12;   // I-type immediate width
    localparam int UW = 20;   // U-type immediate width

    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_IMM32 = 7'b0011011;
    localparam logic [6:0] OPC_LUI   = 7'b0110111;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;
    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [XW-1:0] WORD_BRK = 32'h0010_0073;

    typedef struct packed {
        logic [XW-1:0] word;
        logic          illegal;
        logic          hint;
    } cx_res_t;

    // Build an I-type word
    function automatic logic [XW-1:0] enc_i(input logic [IW-1:0] imm,
                                            input logic [RW-1:0] rs1,
                                            input logic [2:0] f3,
                                            input logic [RW-1:0] rd,
                                            input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    // Build an R-type add
    function automatic logic [XW-1:0] enc_add(input logic [RW-1:0] rs2,
                                              input logic [RW-1:0] rs1,
                                              input logic [RW-1:0] rd);
        return {7'b0, rs2, rs1, 3'b000, rd, OPC_REG};
    endfunction

    // Build a U-type lui
    function automatic logic [XW-1:0] enc_lui(input logic [UW-1:0] imm,
                                              input logic [RW-1:0] rd);
        return {imm, rd, OPC_LUI};
    endfunction
endpackage

// File: rtl/cx_q0.sv
// Module cx_q0
// Expands quadrant 00: only the stack-pointer address generator is in scope;
// every other function code is flagged illegal. Purely combinational.
module cx_q0
    import cx_pkg::*;
(
    input  logic [CW-1:0] ci,
    output cx_res_t       res
);
    logic [9:0] uimm;
    logic [RW-1:0] rdp;

    // Unscramble the scaled immediate and the compact destination
    always_comb begin
        uimm = {ci[10:7], ci[12:11], ci[5], ci[6], 2'b00};
        rdp  = {2'b01, ci[4:2]};
    end

    // Select the expansion and classification
    always_comb begin
        res = '{word: '0, illegal: 1'b1, hint: 1'b0};
        if (ci[15:13] == 3'b000) begin
            res.word    = enc_i({2'b00, uimm}, 5'd2, 3'b000, rdp, OPC_IMM);
            res.illegal = (uimm == 10'd0);
        end
    end
endmodule

// File: rtl/cx_q1.sv
// Module cx_q1
// Expands quadrant 01: add-immediate / no-op, 32-bit add-immediate (64-bit
// width only), load-immediate, load-upper-immediate and stack adjust.
// Jumps, branches and ALU forms of this quadrant are out of scope (illegal).
module cx_q1
    import cx_pkg::*;
(
    input  logic [CW-1:0] ci,
    input  logic          x64,
    output cx_res_t       res
);
    logic [RW-1:0] rd;
    logic [5:0]    k6;
    logic [IW-1:0] simm;
    logic [9:0]    nz16;

    // Field extraction and immediate forms
    always_comb begin
        rd   = ci[11:7];
        k6   = {ci[12], ci[6:2]};
        simm = {{(IW-6){k6[5]}}, k6};
        nz16 = {ci[12], ci[4:3], ci[5], ci[2], ci[6], 4'b0000};
    end

    // Per-function expansion and corner classification
    always_comb begin
        res = '{word: '0, illegal: 1'b1, hint: 1'b0};
        case (ci[15:13])
            3'b000: begin
                res.word    = enc_i(simm, rd, 3'b000, rd, OPC_IMM);
                res.illegal = 1'b0;
                res.hint    = (rd == '0) != (k6 == '0);
            end
            3'b001: begin
                if (x64) begin
                    res.word    = enc_i(simm, rd, 3'b000, rd, OPC_IMM32);
                    res.illegal = (rd == '0);
                end
            end
            3'b010: begin
                res.word    = enc_i(simm, 5'd0, 3'b000, rd, OPC_IMM);
                res.illegal = 1'b0;
                res.hint    = (rd == '0);
            end
            3'b011: begin
                if (rd == 5'd2) begin
                    res.word    = enc_i({{(IW-10){nz16[9]}}, nz16}, 5'd2, 3'b000, 5'd2, OPC_IMM);
                    res.illegal = (nz16 == '0);
                end else begin
                    res.word    = enc_lui({{(UW-6){k6[5]}}, k6}, rd);
                    res.illegal = (k6 == '0);
                    res.hint    = (k6 != '0) && (rd == '0);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cx_q2.sv
// Module cx_q2
// Expands quadrant 10: stack-relative word and doubleword loads and the
// register jump / move / add / breakpoint group. Other codes are illegal.
module cx_q2
    import cx_pkg::*;
(
    input  logic [CW-1:0] ci,
    input  logic          x64,
    output cx_res_t       res
);
    logic [RW-1:0] rd;
    logic [RW-1:0] rs2;
    logic [7:0]    offw;
    logic [8:0]    offd;

    // Field extraction and scaled offsets
    always_comb begin
        rd   = ci[11:7];
        rs2  = ci[6:2];
        offw = {ci[3:2], ci[12], ci[6:4], 2'b00};
        offd = {ci[4:2], ci[12], ci[6:5], 3'b000};
    end

    // Per-function expansion and corner classification
    always_comb begin
        res = '{word: '0, illegal: 1'b1, hint: 1'b0};
        case (ci[15:13])
            3'b010: begin
                res.word    = enc_i({4'b0000, offw}, 5'd2, 3'b010, rd, OPC_LOAD);
                res.illegal = (rd == '0);
            end
            3'b011: begin
                if (x64) begin
                    res.word    = enc_i({3'b000, offd}, 5'd2, 3'b011, rd, OPC_LOAD);
                    res.illegal = (rd == '0);
                end
            end
            3'b100: begin
                if (rs2 == '0) begin
                    if (!ci[12]) begin
                        res.word    = enc_i('0, rd, 3'b000, 5'd0, OPC_JALR);
                        res.illegal = (rd == '0);
                    end else if (rd == '0) begin
                        res.word    = WORD_BRK;
                        res.illegal = 1'b0;
                    end else begin
                        res.word    = enc_i('0, rd, 3'b000, 5'd1, OPC_JALR);
                        res.illegal = 1'b0;
                    end
                end else begin
                    res.word    = enc_add(rs2, ci[12] ? rd : 5'd0, rd);
                    res.illegal = 1'b0;
                    res.hint    = (rd == '0);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cx_expander.sv
// Module cx_expander
// Top of the compressed expander: runs the three quadrant decoders in
// parallel and picks one by the low two bits. Illegal results are forced to a
// zero word with no hint. Non-compressed inputs (low bits 11) are illegal.
module cx_expander
    import cx_pkg::*;
(
    input  logic [15:0] cinsn_i,
    input  logic        xlen64_i,
    output logic [31:0] insn_o,
    output logic        illegal_o,
    output logic        hint_o
);
    localparam int NQ = 3;

    cx_res_t qres [NQ];
    cx_res_t sel;

    cx_q0 u_q0 (.ci(cinsn_i), .res(qres[0]));
    cx_q1 u_q1 (.ci(cinsn_i), .x64(xlen64_i), .res(qres[1]));
    cx_q2 u_q2 (.ci(cinsn_i), .x64(xlen64_i), .res(qres[2]));

    // Quadrant select; the 32-bit quadrant is not expandable
    always_comb begin
        if (cinsn_i[1:0] == 2'b11) sel = '{word: '0, illegal: 1'b1, hint: 1'b0};
        else                       sel = qres[cinsn_i[1:0]];
    end

    // Output gating: illegal results carry no word and no hint
    always_comb begin
        illegal_o = sel.illegal;
        insn_o    = sel.illegal ? '0 : sel.word;
        hint_o    = sel.illegal ? 1'b0 : sel.hint;
    end
endmodule

// File: rtl/cx_expander_chk.sv
// Module cx_expander_chk
// Checker bound to cx_expander: cross-output invariants evaluated on every
// change of the combinational outputs.
module cx_expander_chk (
    input logic [15:0] cinsn_i,
    input logic        xlen64_i,
    input logic [31:0] insn_o,
    input logic        illegal_o,
    input logic        hint_o
);
    // Invariant checks over the port values
    always_comb begin
        if (illegal_o)
            a_r1_illegal_zero_word: assert (insn_o == 32'h0);
        a_r13_flags_exclusive: assert (!(illegal_o && hint_o));
        if (!illegal_o)
            a_r13_legal_length: assert (insn_o[1:0] == 2'b11);
        if (cinsn_i[1:0] == 2'b11)
            a_r1_not_compressed: assert (illegal_o);
        if (!xlen64_i && cinsn_i[1:0] == 2'b10 && cinsn_i[15:13] == 3'b011)
            a_r4_dword_load_needs_64: assert (illegal_o);
        if (!xlen64_i && cinsn_i[1:0] == 2'b01 && cinsn_i[15:13] == 3'b001)
            a_r11_addiw_needs_64: assert (illegal_o);
        if (!illegal_o && cinsn_i[1:0] == 2'b10 && cinsn_i[15:13] == 3'b100
            && cinsn_i[6:2] == 5'd0 && cinsn_i[11:7] != 5'd0)
            a_r5_jump_keeps_source: assert (insn_o[6:0] == 7'b1100111
                                            && insn_o[19:15] == cinsn_i[11:7]);
    end
endmodule

bind cx_expander cx_expander_chk u_chk (
    .cinsn_i(cinsn_i), .xlen64_i(xlen64_i), .insn_o(insn_o),
    .illegal_o(illegal_o), .hint_o(hint_o)
);

// File: tb/cx_expander_test.sv
// Bench cx_expander_test
// Vector table walk, then directed sweeps of immediates and invariants.
module cx_expander_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cinsn;
    logic        x64;
    logic [31:0] insn;
    logic        ill;
    logic        hnt;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cx_expander uut (.cinsn_i(cinsn), .xlen64_i(x64), .insn_o(insn),
                     .illegal_o(ill), .hint_o(hnt));

    // {req, instr, xlen64, expected word, illegal, hint}
    localparam int NV = 38;
    localparam logic [54:0] VEC [NV] = '{
        {4'd2,  16'h0040, 1'b0, 32'h00410413, 1'b0, 1'b0}, // R2 addi x8,x2,4
        {4'd2,  16'h1FFC, 1'b0, 32'h3FC10793, 1'b0, 1'b0}, // R2 max offset
        {4'd2,  16'h0004, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R2 zero imm
        {4'd1,  16'h0000, 1'b1, 32'h00000000, 1'b1, 1'b0}, // R1 all zero
        {4'd1,  16'h0013, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R1 not compressed
        {4'd3,  16'h4522, 1'b0, 32'h00812503, 1'b0, 1'b0}, // R3 lw a0,8(sp)
        {4'd3,  16'h50FE, 1'b0, 32'h0FC12083, 1'b0, 1'b0}, // R3 max offset
        {4'd3,  16'h4002, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R3 rd=0
        {4'd4,  16'h65C2, 1'b1, 32'h01013583, 1'b0, 1'b0}, // R4 ld a1,16(sp)
        {4'd4,  16'h70FE, 1'b1, 32'h1F813083, 1'b0, 1'b0}, // R4 max offset
        {4'd4,  16'h65C2, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R4 32-bit width
        {4'd4,  16'h6002, 1'b1, 32'h00000000, 1'b1, 1'b0}, // R4 rd=0
        {4'd5,  16'h8082, 1'b0, 32'h00008067, 1'b0, 1'b0}, // R5 jr x1
        {4'd5,  16'h8002, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R5 jr x0
        {4'd5,  16'h9282, 1'b0, 32'h000280E7, 1'b0, 1'b0}, // R5 jalr x5
        {4'd5,  16'h9002, 1'b1, 32'h00100073, 1'b0, 1'b0}, // R5 breakpoint
        {4'd6,  16'h852E, 1'b0, 32'h00B00533, 1'b0, 1'b0}, // R6 mv
        {4'd6,  16'h952E, 1'b0, 32'h00B50533, 1'b0, 1'b0}, // R6 add
        {4'd6,  16'h802E, 1'b0, 32'h00B00033, 1'b0, 1'b1}, // R6 mv rd=0 hint
        {4'd6,  16'h902E, 1'b0, 32'h00B00033, 1'b0, 1'b1}, // R6 add rd=0 hint
        {4'd7,  16'h557D, 1'b0, 32'hFFF00513, 1'b0, 1'b0}, // R7 li a0,-1
        {4'd7,  16'h4005, 1'b0, 32'h00100013, 1'b0, 1'b1}, // R7 rd=0 hint
        {4'd8,  16'h6505, 1'b0, 32'h00001537, 1'b0, 1'b0}, // R8 lui 1
        {4'd8,  16'h757D, 1'b0, 32'hFFFFF537, 1'b0, 1'b0}, // R8 lui -1
        {4'd8,  16'h6501, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R8 zero imm
        {4'd8,  16'h6005, 1'b0, 32'h00001037, 1'b0, 1'b1}, // R8 rd=0 hint
        {4'd9,  16'h7101, 1'b0, 32'hE0010113, 1'b0, 1'b0}, // R9 -512
        {4'd9,  16'h617D, 1'b0, 32'h1F010113, 1'b0, 1'b0}, // R9 +496
        {4'd9,  16'h6101, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R9 zero
        {4'd10, 16'h0505, 1'b0, 32'h00150513, 1'b0, 1'b0}, // R10 addi
        {4'd10, 16'h0001, 1'b0, 32'h00000013, 1'b0, 1'b0}, // R10 no-op
        {4'd10, 16'h0005, 1'b0, 32'h00100013, 1'b0, 1'b1}, // R10 no-op imm hint
        {4'd10, 16'h0501, 1'b0, 32'h00050513, 1'b0, 1'b1}, // R10 imm=0 hint
        {4'd11, 16'h357D, 1'b1, 32'hFFF5051B, 1'b0, 1'b0}, // R11 addiw -1
        {4'd11, 16'h2501, 1'b1, 32'h0005051B, 1'b0, 1'b0}, // R11 zero imm legal
        {4'd11, 16'h2501, 1'b0, 32'h00000000, 1'b1, 1'b0}, // R11 32-bit width
        {4'd11, 16'h2005, 1'b1, 32'h00000000, 1'b1, 1'b0}, // R11 rd=0
        {4'd12, 16'hC002, 1'b1, 32'h00000000, 1'b1, 1'b0}  // R12 out of scope
    };

    // Compare outputs with expectations and log failures
    task automatic check(input string req, input logic [31:0] ew,
                         input logic ei, input logic eh);
        checks++;
        if (insn !== ew || ill !== ei || hnt !== eh) begin
            fails++;
            $display("FAIL %s in=%h x64=%b got word=%h ill=%b hint=%b exp word=%h ill=%b hint=%b",
                     req, cinsn, x64, insn, ill, hnt, ew, ei, eh);
        end
    endtask

    // Apply one input away from the clock edge and let it settle
    task automatic drive(input logic [15:0] c, input logic x);
        @(negedge clk);
        cinsn = c;
        x64   = x;
        #2;
    endtask

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Main sequence
    initial begin
        cinsn = 16'h0000;
        x64   = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset-time zero input", 32'h0, 1'b1, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][50:35], VEC[i][34]);
            check($sformatf("R%0d vector %0d", VEC[i][54:51], i),
                  VEC[i][33:2], VEC[i][1], VEC[i][0]);
        end

        // R7 sweep of every load-immediate value into x12
        for (int v = 0; v < 64; v++) begin
            logic [5:0] k;
            k = 6'(v);
            drive({3'b010, k[5], 5'd12, k[4:0], 2'b01}, 1'b0);
            check("R7 sweep", {{6{k[5]}}, k, 5'd0, 3'b000, 5'd12, 7'h13}, 1'b0, 1'b0);
        end

        // R9 sweep of every stack-adjust immediate
        for (int v = 0; v < 64; v++) begin
            logic [5:0]  k;
            logic [11:0] imm;
            k   = 6'(v);  // k = n[9:4]
            imm = {{2{k[5]}}, k, 4'b0000};
            drive({3'b011, k[5], 5'd2, k[0], k[2], k[4:3], k[1], 2'b01}, 1'b0);
            if (k == 6'd0) check("R9 sweep zero", 32'h0, 1'b1, 1'b0);
            else check("R9 sweep", {imm, 5'd2, 3'b000, 5'd2, 7'h13}, 1'b0, 1'b0);
        end

        // R13 and R12 invariants over the whole input space, both widths
        for (int x = 0; x < 2; x++) begin
            for (int c = 0; c < 65536; c++) begin
                logic [15:0] cv;
                logic bad;
                cv = 16'(c);
                cinsn = cv;
                x64 = 1'(x);
                #1;
                bad = (ill && hnt) || (ill && insn != 32'h0) || (!ill && insn[1:0] != 2'b11);
                if (cv[1:0] == 2'b01 && cv[15] == 1'b1) bad = bad || !ill;   // R12
                if (cv[1:0] == 2'b00 && cv[15:13] != 3'b000) bad = bad || !ill; // R12
                checks++;
                if (bad) begin
                    fails++;
                    $display("FAIL R13/R12 in=%h x64=%0d got word=%h ill=%b hint=%b exp consistent flags",
                             cv, x, insn, ill, hnt);
                end
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule